// File: doc/BRIEF.md
# UART receiver break wake-up detector

This block is a small asynchronous serial receiver with a wake-up unit beside it. Software arms the unit by writing a one to the arm bit. While the unit is armed, the receiver stays parked in its idle state. The unit watches the receive line for the falling edge that opens a break or wake-up character, which is all zeros: eight zero bits in plain RS-232 use or twelve for LIN.

When that edge arrives, the unit raises the receive-interrupt flag and places a dummy byte of zero in the data register. Software reads that byte to clear the flag and then discards it. On the next rising edge of the line the arm bit clears itself, and the receiver goes back to normal 8N1 reception.

A receiver-idle output tells software whether a frame is in progress, so it can decide when it is safe to arm. The receive line passes through a two-flop synchronizer, and edges are found by comparing the synchronized line with a copy delayed by one cycle.

Top module: `uart_wake_detector`

## Requirements
- R1: While the arm bit is set, no reception starts: `rx_idle` stays 1 and a long low period on the line loads no data and sets no further flag.
- R2: A falling edge on `rx_in` while armed sets `irq_flag` at the third rising clock edge after the line changes.
- R3: After a wake-up, the next rising edge of the line clears the arm bit (`arm_q` reads 0), and a following 8N1 frame is received normally.
- R4: `irq_flag` stays set until a cycle with `rd_strobe` high, and it reads 0 after that cycle.
- R5: On a wake-up, `rx_data` is loaded with the dummy value 8'h00.
- R6: A rising edge of the line while armed, before any wake-up event, leaves the arm bit set.
- R7: A write to the arm bit while `rx_idle` is 0 is ignored: `arm_q` stays 0 and the frame in progress completes with correct data.
- R8: After reset, `arm_q` is 0, `irq_flag` is 0 and `rx_idle` is 1.
- R9: With the unit disarmed, an 8N1 frame (start bit 0, data LSB first, stop bit 1) sets `irq_flag` and loads the byte into `rx_data`, and `rx_idle` is 0 while the frame is being received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Asynchronous receive line, idle high |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_wdata | input | 1 | Value written to the arm bit |
| arm_q | output | 1 | Readback of the arm bit |
| rd_strobe | input | 1 | Read of the data register; clears the flag |
| irq_flag | output | 1 | Receive-interrupt flag |
| rx_data | output | 8 | Receive data register |
| rx_idle | output | 1 | 1 when no reception is in progress |

## Verification
Some internal faults show at the ports straight away. A stuck arm bit reads back wrong on the next cycle. A wake edge that is missed leaves `irq_flag` low three cycles after the line falls. A missing auto-clear keeps `arm_q` at 1 a few cycles after the line rises again. Other faults only show when a frame ends: a receiver that starts while armed, or a bit counter that is off by one, gives a wrong `rx_data` or a wrong flag about ten bit times after the start bit. The bench therefore samples at these points.

// File: rtl/uart_wake_detector.sv
module uart_wake_detector #(
  parameter int CLKS_PER_BIT = 8,
  parameter int DATA_BITS    = 8,
  parameter logic [7:0] DUMMY_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_in,
  input  logic       arm_wr,
  input  logic       arm_wdata,
  output logic       arm_q,
  input  logic       rd_strobe,
  output logic       irq_flag,
  output logic [7:0] rx_data,
  output logic       rx_idle
);
  localparam int CW   = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int HALF = (CLKS_PER_BIT / 2 > 0) ? CLKS_PER_BIT / 2 : 1;
  localparam int BW   = $clog2(DATA_BITS);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rx_state_t;

  logic rx_s1, rx_s2, rx_d;
  logic armed, woke;
  rx_state_t state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [7:0] shreg;

  wire fall     = rx_d & ~rx_s2;
  wire rise     = ~rx_d & rx_s2;
  wire arm_set  = arm_wr & arm_wdata & rx_idle;
  wire wake     = armed & ~woke & fall;
  wire frame_ok = (state == S_STOP) && (cnt == '0);

  assign rx_idle = (state == S_IDLE);
  assign arm_q   = armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_s1 <= 1'b1;
      rx_s2 <= 1'b1;
      rx_d  <= 1'b1;
    end else begin
      rx_s1 <= rx_in;
      rx_s2 <= rx_s1;
      rx_d  <= rx_s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      woke  <= 1'b0;
    end else if (armed && woke && rise) begin
      armed <= 1'b0;
      woke  <= 1'b0;
    end else begin
      if (wake) woke <= 1'b1;
      if (arm_wr && rx_idle) begin
        armed <= arm_wdata;
        if (!arm_wdata) woke <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (fall && !armed && !arm_set) begin
            state <= S_START;
            cnt   <= CW'(HALF - 1);
          end
        S_START:
          if (cnt == '0) begin
            if (!rx_s2) begin
              state <= S_DATA;
              cnt   <= CW'(CLKS_PER_BIT - 1);
              bitn  <= '0;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_DATA:
          if (cnt == '0) begin
            shreg <= {rx_s2, shreg[7:1]};
            cnt   <= CW'(CLKS_PER_BIT - 1);
            if (bitn == BW'(DATA_BITS - 1)) state <= S_STOP;
            else bitn <= bitn + 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        S_STOP:
          if (cnt == '0) state <= S_IDLE;
          else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_flag <= 1'b0;
      rx_data  <= '0;
    end else if (wake) begin
      irq_flag <= 1'b1;
      rx_data  <= DUMMY_BYTE;
    end else if (frame_ok) begin
      irq_flag <= 1'b1;
      rx_data  <= shreg;
    end else if (rd_strobe) begin
      irq_flag <= 1'b0;
    end
  end

  assert_idle_while_armed_R1: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> rx_idle);
  assert_flag_on_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !woke && fall) |=> irq_flag);
  assert_autoclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && woke && rise) |=> !armed);
  assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !rd_strobe) |=> irq_flag);
  assert_dummy_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(woke) |-> (rx_data == DUMMY_BYTE));
  assert_no_early_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !woke && rise && !arm_wr) |=> armed);
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_wr && !rx_idle && !armed) |=> !armed);
endmodule

// File: tb/test_uart_wake_detector.sv
module test_uart_wake_detector;
  localparam int CPB = 8;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic arm_wr = 1'b0;
  logic arm_wdata = 1'b0;
  logic rd_strobe = 1'b0;
  logic arm_q, irq_flag, rx_idle;
  logic [7:0] rx_data;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_wake_detector #(.CLKS_PER_BIT(CPB)) i_uart_wake_detector (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .arm_wr(arm_wr),
    .arm_wdata(arm_wdata), .arm_q(arm_q), .rd_strobe(rd_strobe),
    .irq_flag(irq_flag), .rx_data(rx_data), .rx_idle(rx_idle));

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic arm_write(input logic v);
    arm_wr = 1'b1; arm_wdata = v;
    tick(1);
    arm_wr = 1'b0; arm_wdata = 1'b0;
  endtask

  task automatic read_data();
    rd_strobe = 1'b1;
    tick(1);
    rd_strobe = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    rx_in = 1'b0; tick(CPB);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; tick(CPB); end
    rx_in = 1'b1; tick(CPB);
  endtask

  initial begin
    tick(3);
    check("R8 arm", arm_q, 0);
    check("R8 flag", irq_flag, 0);
    check("R8 idle", rx_idle, 1);
    rst_n = 1'b1;
    tick(2);

    for (int v = 0; v < NV; v++) begin
      send_byte(VEC[v]);
      tick(2);
      check("R9 flag", irq_flag, 1);
      check("R9 data", rx_data, VEC[v]);
      read_data();
      check("R4 cleared", irq_flag, 0);
    end

    rx_in = 1'b0; tick(CPB);
    for (int i = 0; i < 8; i++) begin
      rx_in = 8'hC6 >> i;
      if (i == 2) begin
        check("R9 busy", rx_idle, 0);
        arm_write(1'b1);
        tick(1);
        check("R7 arm", arm_q, 0);
        tick(CPB - 2);
      end else tick(CPB);
    end
    rx_in = 1'b1; tick(CPB + 2);
    check("R7 data", rx_data, 8'hC6);
    check("R7 flag", irq_flag, 1);
    read_data();

    arm_write(1'b1);
    check("R1 armed", arm_q, 1);
    rx_in = 1'b0;
    tick(2);
    check("R2 not yet", irq_flag, 0);
    tick(1);
    check("R2 wake flag", irq_flag, 1);
    check("R5 dummy", rx_data, 8'h00);
    tick(CPB * 2);
    check("R4 held", irq_flag, 1);
    read_data();
    check("R4 cleared", irq_flag, 0);
    tick(CPB * 10);
    check("R1 idle", rx_idle, 1);
    check("R1 still armed", arm_q, 1);
    rx_in = 1'b1; tick(4);
    check("R3 autoclear", arm_q, 0);
    check("R1 no frame", irq_flag, 0);
    tick(CPB);
    send_byte(8'h69);
    tick(2);
    check("R3 resume flag", irq_flag, 1);
    check("R3 resume data", rx_data, 8'h69);
    read_data();

    rx_in = 1'b0; tick(CPB * 11);
    read_data();
    arm_write(1'b1);
    check("R6 armed", arm_q, 1);
    rx_in = 1'b1; tick(4);
    check("R6 kept", arm_q, 1);
    check("R6 no flag", irq_flag, 0);
    rx_in = 1'b0; tick(4);
    check("R2 second", irq_flag, 1);
    rx_in = 1'b1; tick(4);
    check("R3 autoclear2", arm_q, 0);
    read_data();
    check("R4 cleared2", irq_flag, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        tick(100000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule